// File: doc/BRIEF.md
# Dual-Slope Time Stretch Sequencer

This block is the digital half of a time-amplifying dual-slope time-interval converter. It takes asynchronous start, stop and comparator pulses and a reference clock. It drives three controls for an external analog stage: a discharge control, a charge control for the first integrator and a charge control for the second integrator. While the stretched interval is in progress it counts reference clock cycles. The stretched interval runs from the start event until the comparator reports that both integrator voltages match.

The analog stage lengthens the measured interval by a fixed ratio, one plus the product of the capacitor ratio and the current ratio. The block divides the raw cycle count by that ratio to undo the stretch. The ratio is supplied as an unsigned fixed-point number. A multicycle restoring divider produces the scaled result, and a one-cycle done pulse marks it as valid. Events that arrive in the wrong order set a sticky error flag, and so does an interval that exceeds a programmable cycle limit. In both cases the sequencer goes back to its armed state.

Top module: `stretch_tdc_ctrl`

## Requirements
- R1: Throughout reset, and in every cycle in which neither integrator is charging, `integ_clr_o` is high. After reset `up_o`, `down_o`, `cnt_en_o`, `done_o` and `err_o` are low.
- R2: Each of `start_i`, `stop_i` and `trip_i` passes through a two-flop synchroniser and acts on its rising edge only. When start and stop are each driven one cycle apart from the same clock phase, `up_o` stays high for exactly the number of cycles between them.
- R3: A synchronised stop edge while the first integrator is charging lowers `up_o` and raises `down_o` in the same cycle. `up_o` and `down_o` are never high together.
- R4: A synchronised comparator edge while `down_o` is high ends the measurement, and `down_o` falls. With the bench comparator raised K cycles after `down_o` is first seen high, `down_o` stays high for K+3 cycles.
- R5: `cnt_en_o` is high exactly while `up_o` or `down_o` is high. At the end of a measurement, `count_o` equals the number of cycles in which `cnt_en_o` was high.
- R6: `result_o` = floor(`count_o` × 16 / `factor_i`), where `factor_i` is unsigned with 4 fractional bits. A factor of zero gives a result of all ones.
- R7: `done_o` is a single-cycle pulse that accompanies a new `result_o`. `result_o` and `count_o` then hold until the next accepted start.
- R8: A stop edge while armed, or a comparator edge while armed or while `up_o` is high, sets `err_o`. The block is then left armed, with `up_o` and `down_o` low, and no done pulse is produced.
- R9: If the count reaches `tmo_limit_i` while charging and no comparator edge arrives in that cycle, the block sets `err_o` and returns to armed, with `count_o` equal to the limit. A comparator edge in the limit cycle takes priority and completes normally.
- R10: After each done pulse the block keeps the integrators in discharge for 4 cycles. A start edge that arrives in that window is ignored.
- R11: `err_o` stays set until the next accepted start edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Asynchronous start event |
| stop_i | input | 1 | Asynchronous stop event |
| trip_i | input | 1 | Asynchronous comparator output, high when the integrator voltages match |
| factor_i | input | 8 | Stretch ratio, unsigned, 4 fractional bits |
| tmo_limit_i | input | 16 | Largest count allowed before a timeout error |
| integ_clr_o | output | 1 | Discharge both integration capacitors |
| up_o | output | 1 | Charge the first integrator |
| down_o | output | 1 | Charge the second integrator |
| cnt_en_o | output | 1 | Counter enable across the stretched interval |
| count_o | output | 16 | Raw stretched cycle count |
| result_o | output | 20 | Count divided by the stretch ratio, with 4 fractional bits |
| done_o | output | 1 | One-cycle pulse when result_o is new |
| err_o | output | 1 | Sticky order or timeout error |

## Verification
The bench uses the default parameters: a 16-bit counter, an 8-bit ratio with 4 fractional bits, two-flop synchronisers and a four-cycle discharge dwell. The 20-bit quotient and small stretch intervals let random runs cover ratios from 1/16 up to nearly 16 well within the cycle budget. A 16-bit limit can be set low enough to time out in either charging phase, and it can also be set exactly at the edge where the comparator and the timeout meet.

// File: rtl/stretch_pkg.sv
package stretch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_UP,
        ST_DOWN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic trip;
    } evt_t;

    localparam int EVT_W = $bits(evt_t);

    function automatic logic is_charging(seq_state_e s);
        return (s == ST_UP) || (s == ST_DOWN);
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] stg [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_i;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= '0;
            else     stg[g] <= stg[g-1];
        end
    end

    assign rise_o = stg[STAGES-1] & ~stg[STAGES];
endmodule

// File: rtl/stretch_seq.sv
module stretch_seq
    import stretch_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_t             ev_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             div_done_i,
    output seq_state_e       state_o,
    output logic [CNT_W-1:0] count_o,
    output logic             go_o,
    output logic             err_o
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [RW-1:0]    dwell_q;
    logic             err_q, go_q;
    logic             err_set, err_clr, cnt_clr, cnt_inc, go_d, at_limit;

    assign at_limit = (cnt_q == limit_i);

    always_comb begin
        state_d = state_q;
        err_set = 1'b0;
        err_clr = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        go_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ev_i.start) begin
                    state_d = ST_UP;
                    cnt_clr = 1'b1;
                    err_clr = 1'b1;
                end else if (ev_i.stop || ev_i.trip) begin
                    err_set = 1'b1;
                end
            end
            ST_RESET: begin
                if (dwell_q == '0) state_d = ST_IDLE;
            end
            ST_UP: begin
                if (ev_i.trip || at_limit) begin
                    state_d = ST_IDLE;
                    err_set = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                    if (ev_i.stop) state_d = ST_DOWN;
                end
            end
            ST_DOWN: begin
                if (ev_i.trip) begin
                    state_d = ST_DONE;
                    cnt_inc = 1'b1;
                    go_d    = 1'b1;
                end else if (at_limit) begin
                    state_d = ST_IDLE;
                    err_set = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_DONE: begin
                if (div_done_i) state_d = ST_RESET;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RESET;
            cnt_q   <= '0;
            dwell_q <= RW'(RST_CYCLES - 1);
            err_q   <= 1'b0;
            go_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            go_q    <= go_d;
            if (cnt_clr)      cnt_q <= '0;
            else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
            if (state_d == ST_RESET && state_q != ST_RESET) dwell_q <= RW'(RST_CYCLES - 1);
            else if (state_q == ST_RESET && dwell_q != '0)  dwell_q <= dwell_q - 1'b1;
            if (err_clr)      err_q <= 1'b0;
            else if (err_set) err_q <= 1'b1;
        end
    end

    assign state_o = state_q;
    assign count_o = cnt_q;
    assign go_o    = go_q;
    assign err_o   = err_q;
endmodule

// File: rtl/restoring_div.sv
module restoring_div #(
    parameter int NUM_W = 20,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic             valid_o
);
    localparam int SW = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q, den_q;
    logic [SW-1:0]    left_q;
    logic             busy_q, valid_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign trial = {rem_q, quo_q[NUM_W-1]};
    assign fits  = (trial >= {1'b0, den_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q   <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            left_q  <= '0;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go_i) begin
                quo_q  <= num_i;
                rem_q  <= '0;
                den_q  <= den_i;
                left_q <= SW'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                quo_q  <= {quo_q[NUM_W-2:0], fits};
                rem_q  <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
                left_q <= left_q - 1'b1;
                if (left_q == SW'(1)) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign quo_o   = quo_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/stretch_tdc_ctrl.sv
module stretch_tdc_ctrl
    import stretch_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int FAC_W       = 8,
    parameter int FAC_FRAC    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RST_CYCLES  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      stop_i,
    input  logic                      trip_i,
    input  logic [FAC_W-1:0]          factor_i,
    input  logic [CNT_W-1:0]          tmo_limit_i,
    output logic                      integ_clr_o,
    output logic                      up_o,
    output logic                      down_o,
    output logic                      cnt_en_o,
    output logic [CNT_W-1:0]          count_o,
    output logic [CNT_W+FAC_FRAC-1:0] result_o,
    output logic                      done_o,
    output logic                      err_o
);
    localparam int QW = CNT_W + FAC_FRAC;

    logic [EVT_W-1:0] rise;
    evt_t             ev;
    seq_state_e       state;
    logic [CNT_W-1:0] count;
    logic             go, seq_err, div_valid;
    logic [QW-1:0]    quo, result_q;
    logic             done_q;

    edge_sync #(.WIDTH(EVT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    ({start_i, stop_i, trip_i}),
        .rise_o (rise)
    );
    assign ev = evt_t'(rise);

    stretch_seq #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .limit_i    (tmo_limit_i),
        .div_done_i (div_valid),
        .state_o    (state),
        .count_o    (count),
        .go_o       (go),
        .err_o      (seq_err)
    );

    restoring_div #(.NUM_W(QW), .DEN_W(FAC_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .go_i    (go),
        .num_i   ({count, {FAC_FRAC{1'b0}}}),
        .den_i   (factor_i),
        .quo_o   (quo),
        .valid_o (div_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= div_valid;
            if (div_valid) result_q <= quo;
        end
    end

    assign up_o        = (state == ST_UP);
    assign down_o      = (state == ST_DOWN);
    assign cnt_en_o    = is_charging(state);
    assign integ_clr_o = (state == ST_IDLE) || (state == ST_RESET) || (state == ST_DONE);
    assign count_o     = count;
    assign result_o    = result_q;
    assign done_o      = done_q;
    assign err_o       = seq_err;
endmodule

// File: rtl/stretch_tdc_check.sv
module stretch_tdc_check #(
    parameter int CNT_W = 16,
    parameter int QW    = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             integ_clr_o,
    input logic             up_o,
    input logic             down_o,
    input logic             cnt_en_o,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] tmo_limit_i,
    input logic [QW-1:0]    result_o,
    input logic             done_o,
    input logic             err_o
);
    p_dir_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(up_o && down_o));

    p_handoff_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(up_o) |-> (down_o || err_o));

    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_en_o && $past(cnt_en_o)) |-> (count_o == $past(count_o) + 1'b1));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (integ_clr_o && !cnt_en_o));

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    p_tmo_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_en_o |-> (count_o <= tmo_limit_i));

    p_err_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(up_o) |-> !err_o);
endmodule

bind stretch_tdc_ctrl stretch_tdc_check #(.CNT_W(CNT_W), .QW(CNT_W + FAC_FRAC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .integ_clr_o (integ_clr_o),
    .up_o        (up_o),
    .down_o      (down_o),
    .cnt_en_o    (cnt_en_o),
    .count_o     (count_o),
    .tmo_limit_i (tmo_limit_i),
    .result_o    (result_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/tb_stretch_tdc_ctrl.sv
`timescale 1ns/1ps
module tb_stretch_tdc_ctrl;
    localparam int CNT_W = 16;
    localparam int FAC_W = 8;
    localparam int FRAC  = 4;
    localparam int QW    = CNT_W + FRAC;

    logic clk = 1'b0;
    logic rst, start_i, stop_i, trip_i;
    logic [FAC_W-1:0] factor_i;
    logic [CNT_W-1:0] tmo_limit_i;
    logic integ_clr_o, up_o, down_o, cnt_en_o, done_o, err_o;
    logic [CNT_W-1:0] count_o;
    logic [QW-1:0] result_o;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    stretch_tdc_ctrl dut (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .trip_i(trip_i),
        .factor_i(factor_i), .tmo_limit_i(tmo_limit_i),
        .integ_clr_o(integ_clr_o), .up_o(up_o), .down_o(down_o), .cnt_en_o(cnt_en_o),
        .count_o(count_o), .result_o(result_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint exp_result(input longint cnt, input int fct);
        if (fct == 0) return (longint'(1) << QW) - 1;
        return (cnt << FRAC) / fct;
    endfunction

    task automatic run_meas(input int a, input int k, input int fct, input int lim);
        int ups = 0, downs = 0, ens = 0, dseen = -1, n = 0;
        bit got_done = 0, got_err = 0, hung = 1;
        bit succ;
        longint cnt_exp;
        factor_i    = FAC_W'(fct);
        tmo_limit_i = CNT_W'(lim);
        succ    = (a + k + 2 <= lim);
        cnt_exp = succ ? a + k + 3 : lim;
        start_i = 1'b1;
        for (int g = 0; g < 3000; g++) begin
            @(negedge clk);
            n++;
            start_i = 1'b0;
            if (up_o)     ups++;
            if (down_o)   downs++;
            if (cnt_en_o) ens++;
            if (down_o && dseen < 0) dseen = n;
            stop_i = (n == a);
            trip_i = (dseen >= 0) && (n == dseen + k);
            if (done_o) begin got_done = 1; hung = 0; break; end
            if (err_o && n > 3) begin got_err = 1; hung = 0; break; end
        end
        stop_i = 1'b0;
        trip_i = 1'b0;
        check(!hung, "R4 measurement ends", hung, 0);
        if (succ) begin
            check(got_done && !got_err, "R4 completes", got_done, 1);
            check(ups == a, "R2 up cycles", ups, a);
            check(downs == k + 3, "R4 down cycles", downs, k + 3);
            check(count_o == cnt_exp, "R5 count", count_o, cnt_exp);
            check(ens == cnt_exp, "R5 enable cycles", ens, cnt_exp);
            check(result_o == exp_result(cnt_exp, fct), "R6 result", result_o, exp_result(cnt_exp, fct));
            check(!err_o, "R11 error cleared", err_o, 0);
        end else begin
            check(got_err && !got_done, "R9 timeout error", got_err, 1);
            check(count_o == cnt_exp, "R9 count at limit", count_o, cnt_exp);
            check(!up_o && !down_o, "R9 armed", up_o | down_o, 0);
        end
    endtask

    task automatic settle(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        #1000000;
        fails++;
        total++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        longint held;
        bit saw_up;
        void'($urandom(32'd4242));
        rst = 1'b1; start_i = 0; stop_i = 0; trip_i = 0;
        factor_i = 8'h10; tmo_limit_i = 16'd500;
        repeat (4) @(negedge clk);
        check(integ_clr_o && !up_o && !down_o && !cnt_en_o && !done_o && !err_o,
              "R1 reset state", {integ_clr_o, up_o, down_o, cnt_en_o, done_o, err_o}, 6'b100000);
        rst = 1'b0;
        settle(8);

        // directed: unity ratio and a basic run
        run_meas(5, 2, 16, 500);
        @(negedge clk);
        check(!done_o, "R7 done pulse width", done_o, 0);
        check(integ_clr_o, "R1 discharge after run", integ_clr_o, 1);
        held = result_o;
        settle(10);
        check(result_o == held, "R7 result holds", result_o, held);

        // directed: zero ratio saturates
        run_meas(3, 1, 0, 500);
        settle(10);

        // directed: start inside discharge dwell is ignored
        run_meas(4, 0, 32, 500);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        saw_up = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (up_o) saw_up = 1;
        end
        check(!saw_up, "R10 start in dwell ignored", saw_up, 0);

        // directed: stop while armed
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        settle(5);
        check(err_o && !up_o && !down_o, "R8 stop while armed", err_o, 1);
        settle(5);
        check(err_o, "R11 error sticky", err_o, 0 + 1);

        // directed: comparator while first integrator charges
        run_meas(2, 1, 16, 500);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        settle(3);
        trip_i = 1'b1;
        @(negedge clk);
        trip_i = 1'b0;
        settle(5);
        check(err_o && !up_o && !down_o && integ_clr_o, "R8 trip during up", err_o, 1);
        check(!done_o, "R8 no done", done_o, 0);
        settle(40);

        // directed: timeouts and the limit boundary
        run_meas(5, 20, 16, 15);
        settle(6);
        run_meas(30, 5, 16, 10);
        settle(30);
        run_meas(6, 4, 24, 12);
        settle(10);
        run_meas(6, 5, 24, 12);
        settle(10);

        // constrained random runs
        for (int r = 0; r < 25; r++) begin
            int a, k, f;
            a = 1 + int'($urandom_range(39));
            k = int'($urandom_range(50));
            f = 1 + int'($urandom_range(254));
            run_meas(a, k, f, 500);
            settle(10);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule